// File: doc/BRIEF.md
# Programmable-Format Serial Transmitter

This block turns a parallel character into an asynchronous serial frame on one output line. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop period of one, one and a half or two bit times. When no frame is being sent, the line rests high. All timing comes from a one-cycle enable pulse, `tick_i`, which an external divider raises at sixteen times the bit rate. Each bit therefore lasts sixteen ticks.

A holding register sits in front of the shifter. The host hands over a character with a valid/ready handshake and can load the next character while the current one is still shifting out. The character length, parity mode and stop length are captured when a character moves from the holding register into the shifter. Changing them in the middle of a frame has no effect on that frame. A break control pulls the line low for as long as it is held. A loopback control steers the frame onto an internal line for a neighbouring receiver and parks the external pin at the high level.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, `txd_o` and `loop_txd_o` are 1, and `in_ready_o`, `hold_empty_o` and `tx_empty_o` are all 1.
- R2: A frame begins with a start bit of level 0 lasting 16 ticks. Each data bit follows, least significant bit first, and each lasts 16 ticks.
- R3: `data_len_i` selects the character length. Code 0 means 5 bits, code 1 means 6, code 2 means 7 and code 3 means 8. Input bits above the selected length are not sent.
- R4: With `parity_en_i`=1, one parity bit of 16 ticks follows the data. When `parity_odd_i`=0, this bit is the XOR of the sent data bits (even parity). When `parity_odd_i`=1, it is the inverse of that XOR (odd parity). With `parity_en_i`=0, no parity bit is sent.
- R5: The stop period is level 1. It lasts 16 ticks when `stop_long_i`=0. When `stop_long_i`=1, it lasts 24 ticks with `data_len_i`=0 and 32 ticks otherwise.
- R6: `in_ready_o` is 1 exactly when the holding register is empty. A character is accepted on a clock edge where both `in_valid_i` and `in_ready_o` are 1. The held character moves into the shifter on the first edge at which the shifter is idle, and that shifter cycle starts the start bit.
- R7: `hold_empty_o` rises in the cycle after the held character moves into the shifter. `tx_empty_o` rises only after the last stop tick has finished and the holding register is empty.
- R8: While `break_i`=1 (and `loopback_i`=0), `txd_o` is 0. Frame timing continues underneath, and the line resumes the frame level when break is released.
- R9: While `loopback_i`=1, `txd_o` is 1 and `loop_txd_o` carries the frame. `loop_txd_o` is also forced to 0 by `break_i`.
- R10: The values of `data_len_i`, `parity_en_i`, `parity_odd_i` and `stop_long_i` are captured at the transfer into the shifter. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Enable pulse at 16 times the bit rate |
| data_len_i | input | 2 | Character length code (0..3 means 5..8 bits) |
| parity_en_i | input | 1 | Append a parity bit |
| parity_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_long_i | input | 1 | Long stop period (1.5 or 2 bits) |
| break_i | input | 1 | Force the line to the low level |
| loopback_i | input | 1 | Route the frame to the internal line; hold the pin high |
| in_valid_i | input | 1 | Character offered |
| in_data_i | input | 8 | Character to send |
| in_ready_o | output | 1 | Holding register can accept |
| txd_o | output | 1 | External serial line |
| loop_txd_o | output | 1 | Internal serial line for loopback |
| hold_empty_o | output | 1 | Holding register empty |
| tx_empty_o | output | 1 | Holding register and shifter both empty |

## Verification
The hardest state to reach from the ports is a format change that lands while a frame is already in flight, with a second character waiting in the holding register. Only this case shows whether the format is captured per character at the moment of transfer. The stimulus loads one character, queues a second during the start bit, and then flips length, parity and stop settings mid-frame. The bench model has captured its own copy of the settings at each transfer, so its per-cycle comparison exposes any frame that follows the live inputs. The same per-cycle comparison covers the 24-tick stop period, which appears only with 5-bit characters and the long stop setting, and a break raised and dropped in the middle of a data bit.

// File: rtl/aftx_pkg.sv
package aftx_pkg;

  localparam int AFTX_BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } aftx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
    logic       stop_long;
  } aftx_fmt_t;

  // number of data bits for a length code
  function automatic int aftx_nbits(logic [1:0] len);
    return 5 + int'(len);
  endfunction

  // stop period in ticks: 1, 1.5 (5-bit only) or 2 bit times
  function automatic int aftx_stop_ticks(aftx_fmt_t f, int os);
    if (!f.stop_long) return os;
    if (f.len == 2'd0) return os + os / 2;
    return 2 * os;
  endfunction

  // parity over the bits actually sent
  function automatic logic aftx_parity(logic [AFTX_BYTE_W-1:0] d, aftx_fmt_t f);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < AFTX_BYTE_W; i++) begin
      if (i < aftx_nbits(f.len)) acc = acc ^ d[i];
    end
    return acc ^ f.par_odd;
  endfunction

endpackage

// File: rtl/aftx_hold.sv
module aftx_hold
  import aftx_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid_i,
  input  logic [AFTX_BYTE_W-1:0] in_data_i,
  input  logic                   take_i,
  output logic                   full_o,
  output logic [AFTX_BYTE_W-1:0] data_o
);

  logic                   full_q;
  logic [AFTX_BYTE_W-1:0] data_q;
  logic                   accept_w;

  assign accept_w = in_valid_i && !full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (accept_w) begin
      full_q <= 1'b1;
      data_q <= in_data_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  // R6: a waiting character is never overwritten
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !take_i |=> full_q && $stable(data_q));

  // R7: the holding register empties only through a transfer
  a_r7_empty_by_take: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_q) |-> $past(take_i));

endmodule

// File: rtl/aftx_shifter.sv
module aftx_shifter
  import aftx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic                   load_i,
  input  logic [AFTX_BYTE_W-1:0] load_data_i,
  input  aftx_fmt_t              fmt_i,
  output logic                   idle_o,
  output logic                   bit_o,
  output logic                   done_o
);

  localparam int CNT_W = $clog2(2 * OVERSAMPLE);
  localparam int IDX_W = $clog2(AFTX_BYTE_W);

  aftx_state_e            state_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [IDX_W-1:0]       idx_q;
  logic [AFTX_BYTE_W-1:0] sh_q;
  aftx_fmt_t              fmt_q;
  logic                   par_q;

  logic [CNT_W-1:0] last_cnt_w;
  logic [IDX_W-1:0] last_idx_w;
  logic             bit_end_w;

  always_comb begin
    if (state_q == ST_STOP) last_cnt_w = CNT_W'(aftx_stop_ticks(fmt_q, OVERSAMPLE) - 1);
    else                    last_cnt_w = CNT_W'(OVERSAMPLE - 1);
  end

  assign last_idx_w = IDX_W'(aftx_nbits(fmt_q.len) - 1);
  assign bit_end_w  = tick_i && (state_q != ST_IDLE) && (cnt_q == last_cnt_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      fmt_q   <= '0;
      par_q   <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (load_i) begin
        state_q <= ST_START;
        cnt_q   <= '0;
        idx_q   <= '0;
        sh_q    <= load_data_i;
        fmt_q   <= fmt_i;
        par_q   <= aftx_parity(load_data_i, fmt_i);
      end
    end else if (tick_i) begin
      if (bit_end_w) begin
        cnt_q <= '0;
        unique case (state_q)
          ST_START: state_q <= ST_DATA;
          ST_DATA: begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 1'b1;
            if (idx_q == last_idx_w) state_q <= fmt_q.par_en ? ST_PARITY : ST_STOP;
          end
          ST_PARITY: state_q <= ST_STOP;
          default:   state_q <= ST_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START:  bit_o = 1'b0;
      ST_DATA:   bit_o = sh_q[0];
      ST_PARITY: bit_o = par_q;
      default:   bit_o = 1'b1;
    endcase
  end

  assign idle_o = (state_q == ST_IDLE);
  assign done_o = bit_end_w && (state_q == ST_STOP);

  // R2: the cycle after a load the line shows the start level
  a_r2_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && idle_o |=> !bit_o && !idle_o);

  // R5: the last stop tick is sent at the marking level
  a_r5_stop_marking: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> bit_o);

  // R7: the shifter is idle right after its last stop tick
  a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> idle_o);

  // R5: the tick counter never passes the end of the current bit
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_cnt_w);

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import aftx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [1:0] data_len_i,
  input  logic       parity_en_i,
  input  logic       parity_odd_i,
  input  logic       stop_long_i,
  input  logic       break_i,
  input  logic       loopback_i,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  output logic       in_ready_o,
  output logic       txd_o,
  output logic       loop_txd_o,
  output logic       hold_empty_o,
  output logic       tx_empty_o
);

  aftx_fmt_t              fmt_w;
  logic                   hold_full_w;
  logic [AFTX_BYTE_W-1:0] hold_data_w;
  logic                   sh_idle_w;
  logic                   sh_bit_w;
  logic                   frame_done_w;
  logic                   xfer_w;
  logic                   line_w;

  assign fmt_w  = '{len: data_len_i, par_en: parity_en_i,
                    par_odd: parity_odd_i, stop_long: stop_long_i};
  assign xfer_w = hold_full_w && sh_idle_w;

  aftx_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .take_i     (xfer_w),
    .full_o     (hold_full_w),
    .data_o     (hold_data_w)
  );

  aftx_shifter #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .load_i      (xfer_w),
    .load_data_i (hold_data_w),
    .fmt_i       (fmt_w),
    .idle_o      (sh_idle_w),
    .bit_o       (sh_bit_w),
    .done_o      (frame_done_w)
  );

  assign line_w       = break_i ? 1'b0 : sh_bit_w;
  assign loop_txd_o   = line_w;
  assign txd_o        = loopback_i ? 1'b1 : line_w;
  assign in_ready_o   = !hold_full_w;
  assign hold_empty_o = !hold_full_w;
  assign tx_empty_o   = !hold_full_w && sh_idle_w;

  // R1: an empty transmitter with no break rests at the marking level
  a_r1_idle_marking: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_o && !break_i |-> loop_txd_o);

  // R7: transmitter-empty never rises while a frame is still ending
  a_r7_empty_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty_o) |-> $past(frame_done_w) || $past(xfer_w) == 1'b0);

  // R6: a transfer frees the holding register on the next cycle
  a_r6_ready_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_w |=> in_ready_o && !sh_idle_w);

endmodule

// File: tb/tb_async_frame_tx.sv
module tb_async_frame_tx;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic [1:0] data_len_i = 2'd3;
  logic parity_en_i = 1'b0, parity_odd_i = 1'b0, stop_long_i = 1'b0;
  logic break_i = 1'b0, loopback_i = 1'b0;
  logic in_valid_i = 1'b0;
  logic [7:0] in_data_i = 8'h00;
  logic in_ready_o, txd_o, loop_txd_o, hold_empty_o, tx_empty_o;

  always #2 clk = ~clk;

  async_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .data_len_i(data_len_i),
    .parity_en_i(parity_en_i), .parity_odd_i(parity_odd_i), .stop_long_i(stop_long_i),
    .break_i(break_i), .loopback_i(loopback_i), .in_valid_i(in_valid_i),
    .in_data_i(in_data_i), .in_ready_o(in_ready_o), .txd_o(txd_o),
    .loop_txd_o(loop_txd_o), .hold_empty_o(hold_empty_o), .tx_empty_o(tx_empty_o)
  );

  int checks = 0, errors = 0;
  string cur_req = "R2";

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // tick generator: one enable every second cycle
  int tdiv = 0;
  always @(posedge clk) begin
    #1;
    tdiv = (tdiv + 1) % 2;
    tick_i = (tdiv == 0);
  end

  // reference model: queue of (level, duration) segments
  int  lvl_q[$];
  int  dur_q[$];
  int  rem = 0, cur_lvl = 1;
  bit  m_busy = 0, m_full = 0;
  int  m_data = 0;

  function automatic void build_frame(int d);
    int n, ones;
    n = 5 + int'(data_len_i);
    ones = 0;
    lvl_q.push_back(0); dur_q.push_back(16);
    for (int i = 0; i < n; i++) begin
      lvl_q.push_back((d >> i) & 1); dur_q.push_back(16);
      ones += (d >> i) & 1;
    end
    if (parity_en_i) begin
      lvl_q.push_back(parity_odd_i ? 1 - (ones % 2) : ones % 2);
      dur_q.push_back(16);
    end
    lvl_q.push_back(1);
    dur_q.push_back(!stop_long_i ? 16 : (data_len_i == 0 ? 24 : 32));
  endfunction

  always @(posedge clk) begin
    bit pre_busy, pre_full;
    if (!rst_n) begin
      m_busy = 0; m_full = 0; lvl_q.delete(); dur_q.delete(); cur_lvl = 1;
    end else begin
      pre_busy = m_busy; pre_full = m_full;
      if (m_busy && tick_i) begin
        rem--;
        if (rem == 0) begin
          void'(lvl_q.pop_front()); void'(dur_q.pop_front());
          if (lvl_q.size() == 0) begin m_busy = 0; cur_lvl = 1; end
          else begin cur_lvl = lvl_q[0]; rem = dur_q[0]; end
        end
      end
      if (!pre_busy && pre_full) begin
        build_frame(m_data);
        m_busy = 1; m_full = 0; cur_lvl = lvl_q[0]; rem = dur_q[0];
      end
      if (in_valid_i && !pre_full) begin m_full = 1; m_data = int'(in_data_i); end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    int line;
    if (rst_n) begin
      line = m_busy ? cur_lvl : 1;
      chk(loopback_i ? "R9" : (break_i ? "R8" : cur_req), "txd_o", int'(txd_o),
          loopback_i ? 1 : (break_i ? 0 : line));
      chk(loopback_i ? "R9" : cur_req, "loop_txd_o", int'(loop_txd_o), break_i ? 0 : line);
      chk("R6", "in_ready_o", int'(in_ready_o), m_full ? 0 : 1);
      chk("R7", "hold_empty_o", int'(hold_empty_o), m_full ? 0 : 1);
      chk("R7", "tx_empty_o", int'(tx_empty_o), (!m_full && !m_busy) ? 1 : 0);
    end
  end

  task automatic set_fmt(int len, bit pe, bit po, bit sl);
    data_len_i = 2'(len); parity_en_i = pe; parity_odd_i = po; stop_long_i = sl;
  endtask

  task automatic send(int d);
    bit rdy;
    in_valid_i = 1'b1; in_data_i = 8'(d);
    forever begin
      @(negedge clk); rdy = in_ready_o;
      @(posedge clk); #1;
      if (rdy) break;
    end
    in_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy || m_full) @(negedge clk);
    repeat (6) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "txd_o", int'(txd_o), 1);
    chk("R1", "loop_txd_o", int'(loop_txd_o), 1);
    chk("R1", "in_ready_o", int'(in_ready_o), 1);
    chk("R1", "tx_empty_o", int'(tx_empty_o), 1);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    cur_req = "R2"; set_fmt(3, 0, 0, 0); send(8'hA5); wait_idle();
    cur_req = "R3"; set_fmt(0, 1, 0, 1); send(8'hF3); wait_idle();  // 5 bits, even, 1.5 stop (R5)
    cur_req = "R4"; set_fmt(2, 1, 1, 1); send(8'h5B); wait_idle();  // 7 bits, odd, 2 stop
    cur_req = "R5"; set_fmt(1, 0, 0, 1); send(8'h2C); wait_idle();  // 6 bits, 2 stop

    // R6: second character queued while the first shifts
    cur_req = "R6"; set_fmt(3, 1, 0, 0); send(8'h81); send(8'h7E); send(8'h33); wait_idle();

    // R10: format flipped mid-frame with a character waiting
    cur_req = "R10"; set_fmt(3, 0, 0, 0); send(8'hC6); send(8'h19);
    repeat (40) @(posedge clk); #1;
    set_fmt(0, 1, 1, 1);
    wait_idle();

    // R8: break raised and dropped inside a frame
    cur_req = "R8"; set_fmt(3, 0, 0, 0); send(8'h0F);
    repeat (50) @(posedge clk); #1; break_i = 1'b1;
    repeat (45) @(posedge clk); #1; break_i = 1'b0;
    wait_idle();

    // R9: loopback frame, with a short break inside it
    cur_req = "R9"; loopback_i = 1'b1; set_fmt(1, 1, 0, 0); send(8'h96);
    repeat (30) @(posedge clk); #1; break_i = 1'b1;
    repeat (10) @(posedge clk); #1; break_i = 1'b0;
    wait_idle(); loopback_i = 1'b0;

    // mixed formats back to back
    cur_req = "R3";
    for (int k = 0; k < 12; k++) begin
      set_fmt(k % 4, k[0], k[1], k[2]);
      send((k * 37 + 11) & 8'hFF);
    end
    wait_idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule